// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks one frame of pixel memory line by line and emits read requests for it. Software programs a first-pixel byte address, the number of bytes fetched on each line, the byte stride from one line start to the next, and the number of lines minus one. A one-cycle frame-start pulse then launches the walk. Each line is cut into bursts of 8-byte beats, and no burst is longer than a programmable cap of at most 16 beats. The final burst of a line is shortened so that the line is never overfetched.

A counter tracks the requests that have been accepted but whose data has not yet completed. While that counter equals a programmable limit, no new request is offered. The data return path, the bus protocol and pixel decoding all live outside this block. The block only produces address, burst length and a valid flag under a valid/ready handshake. It also takes a completion pulse for each finished request.

Top module: `scan_fetch_agen`

## Requirements
- R1: After reset `rd_valid` is low and the outstanding count is zero. The burst cap resets to 16 and the outstanding limit resets to `OUT_MAX`.
- R2: Following a `frame_start` pulse, the first request carries the base address, written at `cfg_sel`=0.
- R3: Within a line, each accepted burst of N beats moves the next address up by 8·N bytes. A line fetches exactly floor(line bytes / 8) beats, where line bytes are written at `cfg_sel`=1. Every burst is min(beats left, cap).
- R4: The first request of each following line is at the previous line start plus the pitch, written at `cfg_sel`=2.
- R5: A frame issues exactly (count+1)·ceil(beats/cap) requests, where the count is written at `cfg_sel`=3. After that `rd_valid` stays low.
- R6: A line count written above `MAX_LINES`−2 is stored as `MAX_LINES`−2, so a frame never exceeds `MAX_LINES`−1 lines.
- R7: The burst cap is option bits [4:0], written at `cfg_sel`=4. A value of 0 or above 16 means 16.
- R8: The outstanding limit is option bits [11:8] plus one. `rd_valid` is low while the count equals the limit. Each `rd_ready` handshake adds one to the count, and each `rd_done` pulse removes one.
- R9: A request that is offered but not accepted keeps its address and length on the next cycle.
- R10: A `frame_start` during a frame abandons it and restarts from the base address.
- R11: A line length below 8 bytes (zero beats) makes a frame issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 base, 1 line bytes, 2 pitch, 3 lines−1, 4 options) |
| cfg_data | input | AW | Register write data |
| frame_start | input | 1 | One-cycle pulse starting a frame walk |
| rd_ready | input | 1 | Request accepted by the bus |
| rd_done | input | 1 | Data of one outstanding request completed |
| rd_valid | output | 1 | Request offered |
| rd_addr | output | AW | Byte address of the burst |
| rd_beats | output | 5 | Burst length in 8-byte beats (1..16) |

## Verification
Frames are run with line lengths that divide the burst cap evenly, leave a short tail, or fall below one beat. These patterns separate correct tail shortening from overfetch or a missing final burst. A sweep over every cap encoding from 0 to 17 against line lengths of 1 to 20 beats exercises the clamping of illegal caps and the ceil-division of requests per line. Ready stall patterns and slow completion patterns are combined with outstanding limits from 1 to 4, to tell request holding and throttling apart from lost or duplicated requests. Separate frames cover an oversized line count, a restart in mid-frame and a zero-beat line.

// File: rtl/scan_fetch_agen.sv
module scan_fetch_agen #(
  parameter int AW        = 32,
  parameter int LBW       = 16,
  parameter int MAX_LINES = 4096,
  parameter int BURST_MAX = 16,
  parameter int OUT_MAX   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          frame_start,
  input  logic          rd_ready,
  input  logic          rd_done,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [4:0]    rd_beats
);
  localparam int BTW = LBW - 3;
  localparam int LCW = $clog2(MAX_LINES);
  localparam int OLW = $clog2(OUT_MAX);
  localparam int OCW = $clog2(OUT_MAX + 1);

  logic [AW-1:0]  base_q, pitch_q, addr_q, lbase_q;
  logic [BTW-1:0] beats_q, left_q;
  logic [LCW-1:0] lines_q, line_q;
  logic [4:0]     cap_q;
  logic [OCW-1:0] lim_q, outst_q;
  logic           active_q;

  wire [4:0]     cap_f   = cfg_data[4:0];
  wire [BTW-1:0] cap_ext = BTW'(cap_q);
  wire [BTW-1:0] burst   = (left_q < cap_ext) ? left_q : cap_ext;
  wire           last    = (left_q == burst);
  wire           hs      = rd_valid && rd_ready;
  wire [AW-1:0]  next_ln = lbase_q + pitch_q;

  assign rd_valid = active_q && (outst_q < lim_q);
  assign rd_addr  = addr_q;
  assign rd_beats = burst[4:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      pitch_q <= '0;
      beats_q <= '0;
      lines_q <= '0;
      cap_q   <= 5'(BURST_MAX);
      lim_q   <= OCW'(OUT_MAX);
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: base_q  <= cfg_data;
        3'd1: beats_q <= cfg_data[LBW-1:3];
        3'd2: pitch_q <= cfg_data;
        3'd3: lines_q <= (cfg_data > AW'(MAX_LINES - 2)) ? LCW'(MAX_LINES - 2)
                                                        : cfg_data[LCW-1:0];
        3'd4: begin
          cap_q <= (cap_f == 5'd0 || cap_f > 5'(BURST_MAX)) ? 5'(BURST_MAX) : cap_f;
          lim_q <= OCW'(cfg_data[8 +: OLW]) + OCW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      lbase_q  <= '0;
      left_q   <= '0;
      line_q   <= '0;
    end else if (frame_start) begin
      active_q <= (beats_q != '0);
      addr_q   <= base_q;
      lbase_q  <= base_q;
      left_q   <= beats_q;
      line_q   <= '0;
    end else if (hs) begin
      if (!last) begin
        addr_q <= addr_q + (AW'(burst) << 3);
        left_q <= left_q - burst;
      end else if (line_q == lines_q) begin
        active_q <= 1'b0;
      end else begin
        line_q  <= line_q + LCW'(1);
        lbase_q <= next_ln;
        addr_q  <= next_ln;
        left_q  <= beats_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      outst_q <= '0;
    else if (hs && !rd_done)
      outst_q <= outst_q + OCW'(1);
    else if (!hs && rd_done && outst_q != '0)
      outst_q <= outst_q - OCW'(1);
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_valid && outst_q == '0);

  a_r7_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_beats != 5'd0 && rd_beats <= 5'(BURST_MAX));

  a_r8_outst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !cfg_we) |=> outst_q <= lim_q);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !frame_start && !cfg_we)
      |=> rd_valid && $stable(rd_addr) && $stable(rd_beats));
endmodule

// File: tb/scan_fetch_agen_tb.sv
module scan_fetch_agen_tb;
  localparam int ML = 8;
  logic clk = 0, rst_n = 0, cfg_we = 0, frame_start = 0, rd_ready = 0, rd_done = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_data = 0;
  logic rd_valid;
  logic [31:0] rd_addr;
  logic [4:0] rd_beats;

  scan_fetch_agen #(.MAX_LINES(ML)) u_dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit run = 0, fs_req = 0, stall = 0;
  int rdy_mode = 0, done_mode = 0;
  bit m_active = 0;
  logic [31:0] m_addr, m_lbase, m_base, m_pitch;
  int m_left, m_line, m_beats, m_lm1, m_cap = 16, m_lim = 16, m_out = 0, n_hs = 0;

  task automatic fail(string tag, string what, longint act, longint exp);
    nerr++;
    $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  always @(negedge clk) if (run) begin
    bit ev, rdy, dn, fs, hs;
    int eb;
    string tag;
    cyc++;
    ev = m_active && (m_out < m_lim);
    eb = (m_left < m_cap) ? m_left : m_cap;
    tag = stall ? "R9" : (m_left == m_beats && m_line == 0) ? "R2" :
          (m_left == m_beats) ? "R4" : "R3";
    if (m_active && !ev) tag = "R8";
    if (!m_active) tag = "R5";
    chk(tag, "rd_valid", rd_valid, ev);
    if (ev) begin
      chk(tag, "rd_addr", rd_addr, m_addr);
      chk((m_left >= m_cap) ? "R7" : "R3", "rd_beats", rd_beats, eb);
    end
    case (rdy_mode)
      0: rdy = 1;
      1: rdy = cyc % 2;
      default: rdy = (cyc % 3 == 0);
    endcase
    case (done_mode)
      0: dn = 1;
      1: dn = (cyc % 4 == 0);
      default: dn = (cyc % 7 == 0);
    endcase
    dn = dn && (m_out > 0);
    fs = fs_req;
    if (fs) begin rdy = 0; fs_req = 0; end
    hs = ev && rdy;
    stall = ev && !rdy && !fs;
    if (fs) begin
      m_active = (m_beats != 0); m_addr = m_base; m_lbase = m_base;
      m_left = m_beats; m_line = 0; n_hs = 0;
    end else if (hs) begin
      n_hs++;
      if (m_left > m_cap) begin
        m_addr += 32'(eb * 8); m_left -= eb;
      end else if (m_line == m_lm1) m_active = 0;
      else begin
        m_line++; m_lbase += m_pitch; m_addr = m_lbase; m_left = m_beats;
      end
    end
    m_out += int'(hs) - int'(dn);
    frame_start = fs; rd_ready = rdy; rd_done = dn;
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = 3'(sel); cfg_data = d;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic setup(logic [31:0] base, int bytes, logic [31:0] pitch, int lm1, logic [31:0] opt);
    int f;
    wr(0, base); wr(1, 32'(bytes)); wr(2, pitch); wr(3, 32'(lm1)); wr(4, opt);
    m_base = base; m_beats = (bytes % 65536) / 8; m_pitch = pitch;
    m_lm1 = (lm1 > ML - 2) ? ML - 2 : lm1;
    f = int'(opt[4:0]);
    m_cap = (f == 0 || f > 16) ? 16 : f;
    m_lim = int'(opt[11:8]) + 1;
  endtask

  task automatic finish_frame(string tag);
    int exp, n;
    fs_req = 1;
    n = 0;
    while ((fs_req || m_active || m_out != 0) && n < 5000) begin @(posedge clk); n++; end
    if (n >= 5000) fail(tag, "frame did not complete", n, 0);
    exp = (m_beats == 0) ? 0 : (m_lm1 + 1) * ((m_beats + m_cap - 1) / m_cap);
    repeat (3) @(posedge clk);
    chk(tag, "request count", n_hs, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rd_valid after reset", rd_valid, 0);
    run = 1;
    rdy_mode = 0; done_mode = 0;
    setup(32'h1000, 64, 128, 3, 32'h0000_0310);
    finish_frame("R5");
    rdy_mode = 1; done_mode = 1;
    setup(32'h2000_0008, 200, 256, 2, 32'h0000_0F10);
    finish_frame("R3");
    rdy_mode = 2; done_mode = 2;
    setup(32'h400, 96, 96, 4, 32'h0000_0004);
    finish_frame("R8");
    rdy_mode = 0; done_mode = 1;
    setup(32'h8000, 320, 512, 1, 32'h0000_011F);
    finish_frame("R7");
    setup(32'h8000, 320, 512, 1, 32'h0000_0100);
    finish_frame("R7");
    setup(32'h100, 16, 64, 100, 32'h0000_0F10);
    finish_frame("R6");
    chk("R6", "clamped line count", m_lm1, ML - 2);
    rdy_mode = 1; done_mode = 0;
    setup(32'h3000, 128, 256, 3, 32'h0000_0F04);
    fs_req = 1;
    repeat (12) @(posedge clk);
    finish_frame("R10");
    setup(32'h500, 7, 64, 2, 32'h0000_0F10);
    fs_req = 1;
    repeat (20) @(posedge clk);
    chk("R11", "requests for zero-beat line", n_hs, 0);
    chk("R11", "rd_valid for zero-beat line", rd_valid, 0);
    for (int c = 0; c < 18; c++)
      for (int b = 1; b <= 20; b++) begin
        rdy_mode = (b + c) % 3; done_mode = c % 3;
        setup(32'(b * 4096), b * 8, 32'(b * 8 + 24), 1, 32'(((c % 4) << 8) | c));
        finish_frame("R5");
      end
    run = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule